// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address of every beat of one SDRAM burst. A controller loads a configuration word that selects the burst length and the beat ordering, then pulses a start input with the first column of the access. From the next cycle on, the block presents one column address per cycle, together with a valid flag and a flag on the final beat. Sequential bursts count upward inside the aligned block that the burst length defines. Interleaved bursts XOR the beat index into the start column's low bits. A full-page burst walks every column of the row, wraps from the top column back to column 0, and keeps running until the controller asserts terminate.

A burst-read / single-write option makes every write access a single beat, while reads keep the programmed length. The configuration in force is taken at the moment a burst starts, so a new configuration can be loaded at any time without disturbing a burst that is already running. Command sequencing and the data path belong to the surrounding controller.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, col_vld and col_last are 0, and the configuration is burst length 1, sequential ordering, with writes that burst normally.
- R2: The cycle after start is sampled, col_vld is 1 and col_addr equals start_col.
- R3: With sequential ordering (mode_word bit 3 = 0) and burst length BL, beat i is the start column with its low log2(BL) bits replaced by (start low bits + i) mod BL. The upper bits stay fixed.
- R4: With interleaved ordering (mode_word bit 3 = 1) and burst length BL, beat i is the start column with its low log2(BL) bits replaced by (start low bits XOR i).
- R5: mode_word bits [2:0] select the length: code 0 = 1, 1 = 2, 2 = 4, 3 = 8 beats. col_last is 1 only on the final beat, and col_vld is 0 in the cycle after it unless a new start was sampled.
- R6: A burst of length 1 outputs exactly start_col for one cycle, with col_last set.
- R7: Length code 7 selects full page. It is always sequential, whatever bit 3 says, wraps from column 255 to 0, never raises col_last, and runs until stop.
- R8: stop sampled during an active burst makes col_vld 0 in the next cycle. If start is sampled in the same cycle, start wins and a new burst begins.
- R9: With mode_word bit 9 = 1 (single-write), a start with start_is_write = 1 gives one beat with col_last set, and a start with start_is_write = 0 uses the programmed length.
- R10: The reserved length codes 4, 5 and 6 behave as length 1.
- R11: mode_load applies only to bursts that start after it is sampled. A running burst keeps its length and ordering, and a start sampled in the same cycle as a load uses the previous configuration.
- R12: A start sampled during an active burst abandons that burst and begins the new one at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Load mode_word into the configuration register |
| mode_word | input | 12 | Configuration: [2:0] length code, [3] ordering, [9] single-write |
| start | input | 1 | Begin a burst at start_col |
| start_col | input | 8 | First column of the burst |
| start_is_write | input | 1 | The access being started is a write |
| stop | input | 1 | Terminate the active burst |
| col_vld | output | 1 | A column address is presented this cycle |
| col_addr | output | 8 | Column address of the current beat |
| col_last | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
Every start column is swept for each fixed length under both orderings. This catches a sequencer that carries out of the aligned block, disturbs the upper column bits, or adds where it should XOR. Full-page bursts are run across the 255-to-0 boundary with the ordering bit set: a design that honours that bit or stops at the row end would produce wrong columns or a stray last flag. The bench also hits a configuration load landing mid-burst or on the start cycle, a start coinciding with stop, a restart in mid-burst, the reserved codes, and single-write starts. Each would expose a design that samples its configuration late, lets stop outrank start, or keeps the stale beat index.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int unsigned KW = 4;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } ord_e;

  typedef struct packed {
    logic [KW-1:0] k;          // log2 of burst length (COL_W for full page)
    ord_e          ord;
    logic          full;
    logic          single_wr;
  } burst_cfg_t;

endpackage

// File: rtl/bseq_mode_reg.sv
module bseq_mode_reg
  import burst_seq_pkg::*;
#(
  parameter int unsigned MODE_W = 12,
  parameter int unsigned COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output burst_cfg_t        cfg
);

  localparam logic [KW-1:0] K_FULL = KW'(COL_W);

  burst_cfg_t cfg_d;
  burst_cfg_t cfg_q;

  logic unused_bits;
  assign unused_bits = ^{word[8:4], word[MODE_W-1:10]};

  always_comb begin
    cfg_d           = '0;
    cfg_d.single_wr = word[9];
    case (word[2:0])
      3'd0:    cfg_d.k = KW'(0);
      3'd1:    cfg_d.k = KW'(1);
      3'd2:    cfg_d.k = KW'(2);
      3'd3:    cfg_d.k = KW'(3);
      3'd7: begin
        cfg_d.k    = K_FULL;
        cfg_d.full = 1'b1;
      end
      default: cfg_d.k = KW'(0);
    endcase
    cfg_d.ord = (word[3] && !cfg_d.full) ? ORD_ILV : ORD_SEQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (load) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

  // R7
  full_is_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.full |-> (cfg_q.ord == ORD_SEQ && cfg_q.k == K_FULL));

  // R10
  fixed_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.full |-> (cfg_q.k <= KW'(3)));

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_q));

endmodule

// File: rtl/bseq_beat_ctrl.sv
module bseq_beat_ctrl
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_is_write,
  input  logic             stop,
  input  burst_cfg_t       cfg,
  output logic             act,
  output logic [COL_W-1:0] idx,
  output logic [COL_W-1:0] base,
  output logic [KW-1:0]    k,
  output ord_e             ord,
  output logic             last
);

  localparam logic [COL_W-1:0] ONES = {COL_W{1'b1}};

  logic             act_q,  act_d;
  logic [COL_W-1:0] idx_q,  idx_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [KW-1:0]    k_q,    k_d;
  ord_e             ord_q,  ord_d;
  logic             full_q, full_d;
  logic             upd_en;
  logic             one_beat;
  logic [COL_W-1:0] idx_max;

  assign one_beat = cfg.single_wr && start_is_write;
  assign idx_max  = ~(ONES << k_q);
  assign last     = act_q && !full_q && (idx_q == idx_max);
  assign upd_en   = start || act_q;

  always_comb begin
    act_d  = act_q;
    idx_d  = idx_q;
    base_d = base_q;
    k_d    = k_q;
    ord_d  = ord_q;
    full_d = full_q;
    if (start) begin
      act_d  = 1'b1;
      idx_d  = '0;
      base_d = start_col;
      k_d    = one_beat ? KW'(0) : cfg.k;
      ord_d  = one_beat ? ORD_SEQ : cfg.ord;
      full_d = cfg.full && !one_beat;
    end else if (act_q) begin
      if (stop || last) begin
        act_d = 1'b0;
      end else begin
        idx_d = idx_q + COL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
      k_q    <= '0;
      ord_q  <= ORD_SEQ;
      full_q <= 1'b0;
    end else if (upd_en) begin
      act_q  <= act_d;
      idx_q  <= idx_d;
      base_q <= base_d;
      k_q    <= k_d;
      ord_q  <= ord_d;
      full_q <= full_d;
    end
  end

  assign act  = act_q;
  assign idx  = idx_q;
  assign base = base_q;
  assign k    = k_q;
  assign ord  = ord_q;

  // R7
  full_never_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && full_q) |-> !last);

  // R3
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !start && !stop && !last) |=> (idx_q == $past(idx_q) + COL_W'(1)));

  // R12
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (act_q && idx_q == '0 && base_q == $past(start_col)));

endmodule

// File: rtl/bseq_addr_map.sv
module bseq_addr_map
  import burst_seq_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [KW-1:0]    k,
  input  ord_e             ord,
  output logic [COL_W-1:0] addr
);

  localparam logic [COL_W-1:0] ONES = {COL_W{1'b1}};

  logic [COL_W-1:0] low_mask;
  logic [COL_W-1:0] low_seq;
  logic [COL_W-1:0] low_ilv;
  logic [COL_W-1:0] low_sel;

  always_comb begin
    low_mask = ~(ONES << k);
    low_seq  = base + idx;
    low_ilv  = base ^ idx;
    low_sel  = (ord == ORD_ILV) ? low_ilv : low_seq;
    addr     = (base & ~low_mask) | (low_sel & low_mask);
  end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned MODE_W = 12,
  parameter int unsigned COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              start_is_write,
  input  logic              stop,
  output logic              col_vld,
  output logic [COL_W-1:0]  col_addr,
  output logic              col_last
);

  burst_cfg_t       cfg;
  logic             act;
  logic [COL_W-1:0] idx;
  logic [COL_W-1:0] base;
  logic [KW-1:0]    k;
  ord_e             ord;
  logic             last;

  bseq_mode_reg #(.MODE_W(MODE_W), .COL_W(COL_W)) u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (mode_load),
    .word  (mode_word),
    .cfg   (cfg)
  );

  bseq_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .start_col      (start_col),
    .start_is_write (start_is_write),
    .stop           (stop),
    .cfg            (cfg),
    .act            (act),
    .idx            (idx),
    .base           (base),
    .k              (k),
    .ord            (ord),
    .last           (last)
  );

  bseq_addr_map #(.COL_W(COL_W)) u_map (
    .base (base),
    .idx  (idx),
    .k    (k),
    .ord  (ord),
    .addr (col_addr)
  );

  assign col_vld  = act;
  assign col_last = last;

  // R5
  last_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_vld);

  // R2
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_vld && col_addr == $past(start_col)));

  // R5
  end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last && !start) |=> !col_vld);

  // R8
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld && stop && !start) |=> !col_vld);

endmodule

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_load;
  logic [11:0] mode_word;
  logic        start;
  logic [7:0]  start_col;
  logic        start_is_write;
  logic        stop;
  logic        col_vld;
  logic [7:0]  col_addr;
  logic        col_last;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  burst_col_seq u_burst_col_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_load      (mode_load),
    .mode_word      (mode_word),
    .start          (start),
    .start_col      (start_col),
    .start_is_write (start_is_write),
    .stop           (stop),
    .col_vld        (col_vld),
    .col_addr       (col_addr),
    .col_last       (col_last)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_addr(input int col, input int i, input int k, input bit ilv);
    int blk = 1 << k;
    int off = col % blk;
    int hi  = col - off;
    if (ilv) return hi + (off ^ i);
    return hi + ((off + i) % blk);
  endfunction

  task automatic set_mode(input int code, input bit ilv, input bit sw);
    @(negedge clk);
    mode_load = 1'b1;
    mode_word = {2'b00, sw, 5'b10110, ilv, 3'(code)};
    @(negedge clk);
    mode_load = 1'b0;
  endtask

  task automatic burst(input int col, input bit wr, input int k, input bit ilv, input string tag);
    int len = 1 << k;
    @(negedge clk);
    start = 1'b1; start_col = 8'(col); start_is_write = wr;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      start = 1'b0;
      chk({tag, " vld"}, int'(col_vld), 1);
      chk({tag, " addr"}, int'(col_addr), exp_addr(col, i, k, ilv));
      chk({tag, " last"}, int'(col_last), (i == len - 1) ? 1 : 0);
    end
    @(negedge clk);
    chk({tag, " end"}, int'(col_vld), 0);
  endtask

  initial begin
    rst_n = 1'b0; mode_load = 1'b0; mode_word = '0; start = 1'b0;
    start_col = '0; start_is_write = 1'b0; stop = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset vld", int'(col_vld), 0);
    chk("R1 reset last", int'(col_last), 0);
    rst_n = 1'b1;
    // R1 default config: length 1
    burst(8'h5a, 1'b1, 0, 1'b0, "R1 default");

    // R3 R4 R5 R6 sweep, writes behave as reads when single-write is off
    for (int o = 0; o < 2; o++) begin
      for (int k = 0; k < 4; k++) begin
        set_mode(k, o[0], 1'b0);
        for (int c = 0; c < 256; c++)
          burst(c, c[0], k, o[0], o[0] ? "R4 ilv" : (k == 0 ? "R6 bl1" : "R3 seq"));
      end
    end

    // R10 reserved codes
    for (int code = 4; code < 7; code++) begin
      set_mode(code, 1'b1, 1'b0);
      burst(8'h37, 1'b0, 0, 1'b0, "R10 reserved");
      burst(8'hfe, 1'b0, 0, 1'b0, "R10 reserved");
    end

    // R9 single-write
    set_mode(3, 1'b0, 1'b1);
    burst(8'h2d, 1'b1, 0, 1'b0, "R9 single wr");
    burst(8'h2d, 1'b0, 3, 1'b0, "R9 read bursts");
    set_mode(3, 1'b1, 1'b1);
    burst(8'hc3, 1'b1, 0, 1'b0, "R9 single wr ilv");
    burst(8'hc3, 1'b0, 3, 1'b1, "R9 read ilv");

    // R7 full page, ordering bit set but ignored; R8 stop
    set_mode(7, 1'b1, 1'b0);
    @(negedge clk);
    start = 1'b1; start_col = 8'd250; start_is_write = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      start = 1'b0;
      chk("R7 full vld", int'(col_vld), 1);
      chk("R7 full addr", int'(col_addr), (250 + i) % 256);
      chk("R7 full last", int'(col_last), 0);
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R8 stop ends", int'(col_vld), 0);

    // R8 start wins over stop
    @(negedge clk);
    start = 1'b1; start_col = 8'd100;
    repeat (3) @(negedge clk) start = 1'b0;
    start = 1'b1; stop = 1'b1; start_col = 8'd5;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    chk("R8 start wins vld", int'(col_vld), 1);
    chk("R8 start wins addr", int'(col_addr), 5);
    @(negedge clk);
    chk("R8 continues", int'(col_addr), 6);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R8 stop ends", int'(col_vld), 0);

    // R8 stop within fixed-length burst
    set_mode(3, 1'b0, 1'b0);
    @(negedge clk);
    start = 1'b1; start_col = 8'h40;
    @(negedge clk);
    start = 1'b0; stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R8 stop fixed", int'(col_vld), 0);

    // R12 restart mid-burst
    @(negedge clk);
    start = 1'b1; start_col = 8'h10;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R12 before restart", int'(col_addr), 8'h11);
    burst(8'h47, 1'b0, 3, 1'b0, "R12 restart");

    // R11 load during burst keeps running config
    set_mode(2, 1'b0, 1'b0);
    @(negedge clk);
    start = 1'b1; start_col = 8'd3;
    @(negedge clk);
    start = 1'b0;
    mode_load = 1'b1; mode_word = 12'h000;
    chk("R11 beat0", int'(col_addr), 3);
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      mode_load = 1'b0;
      chk("R11 kept addr", int'(col_addr), exp_addr(3, i, 2, 1'b0));
      chk("R11 kept last", int'(col_last), (i == 3) ? 1 : 0);
    end
    @(negedge clk);
    chk("R11 kept end", int'(col_vld), 0);
    burst(8'd3, 1'b0, 0, 1'b0, "R11 new cfg");
    // R11 load and start in the same cycle: start uses old length 1
    @(negedge clk);
    mode_load = 1'b1; mode_word = 12'h003; start = 1'b1; start_col = 8'd9;
    @(negedge clk);
    mode_load = 1'b0; start = 1'b0;
    chk("R11 same cycle addr", int'(col_addr), 9);
    chk("R11 same cycle last", int'(col_last), 1);
    @(negedge clk);
    chk("R11 same cycle end", int'(col_vld), 0);
    burst(8'd9, 1'b0, 3, 1'b0, "R11 after load");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule